// File: doc/BRIEF.md
# Asynchronous SRAM Port Timing Sequencer

This block sits between a synchronous requester and one port of an asynchronous static RAM that has 12-bit addresses, 9-bit data and no chip enable. It accepts one single-word read or write at a time over a valid/ready handshake. It then plays out the address, the active-low write strobe, the active-low output enable and the direction of the data bus, so that every minimum time of the RAM is met at the configured clock period. Each write and each read runs to the end of its own recovery interval before the next request is taken.

All RAM timings are parameters given in nanoseconds, next to a clock-period parameter. Each one becomes a cycle count by rounding the quotient up, with at least one cycle per phase. The address is only ever updated in the cycle a request is accepted. The write strobe is high on both sides of that edge, because the RAM has no chip enable to mask an address change.

A mode parameter chooses how output enable behaves during a write. In the default mode, output enable stays high through the whole write, and the pulse uses the plain minimum width. In the stretched mode, output enable is low during the write. The controller then waits out the RAM's turn-off time before it drives the bus, and it lengthens the pulse to cover that wait plus the data setup time.

Top module: `sram_port_seq`

## Requirements
- R1: While rst_ni is low, ram_we_n_o and ram_oe_n_o are high, ram_dq_oe_o and rd_done_o are low, and req_ready_o is high once the reset has been applied.
- R2: ram_addr_o changes only at a clock edge where ram_we_n_o is high both before and after that edge.
- R3: In the default mode a write holds ram_we_n_o low for max(ceil(t_wp/T), ceil(t_dw/T), ceil(t_aw/T)-1) cycles, where T is the clock period. With defaults at 4 ns this is 3 cycles, starting one cycle after acceptance.
- R4: In the default mode ram_oe_n_o stays high in every cycle in which ram_we_n_o is low.
- R5: In the stretched mode ram_oe_n_o is low during the write. ram_dq_oe_o first rises ceil(t_wz/T) cycles after ram_we_n_o falls, which is 2 cycles at 4 ns. The pulse lasts at least that wait plus ceil(t_dw/T), which is 4 cycles at 4 ns.
- R6: ram_dq_oe_o is never high while the RAM may drive the bus. That is never while ram_we_n_o is high and ram_oe_n_o is low, nor in the ceil(t_hz/T) cycles after such a cycle ends.
- R7: Write data on ram_dq_o is driven from the drive point until after ram_we_n_o rises, so the data in the last low-strobe cycle is stored. A later read of the same address returns the most recent write.
- R8: A read holds ram_oe_n_o low for max(ceil(t_aa/T)-1, ceil(t_aoe/T)) cycles, which is 2 at 4 ns, starting one cycle after acceptance. ram_dq_i is captured at the edge that ends the last of those cycles. rd_done_o is high for exactly one cycle, in the cycle that rd_data_o first shows the captured word (the 4th cycle after acceptance at 4 ns). Writes never raise rd_done_o.
- R9: req_ready_o is low from the cycle after acceptance until recovery ends. A write recovers for max(ceil(t_wr/T), ceil(t_wc/T)-1-pulse) cycles (at least 1), and a read for ceil(t_hz/T) cycles. At 4 ns a write is busy for 5 cycles (6 in the stretched mode) and a read for 5 cycles.
- R10: Requests presented while req_ready_o is low are ignored. The address, direction and data in flight do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Word address |
| req_wdata_i | input | 9 | Write data |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| rd_data_o | output | 9 | Last word read |
| rd_done_o | output | 1 | One-cycle pulse: rd_data_o holds a new word |
| ram_addr_o | output | 12 | RAM address |
| ram_we_n_o | output | 1 | RAM write strobe, active low |
| ram_oe_n_o | output | 1 | RAM output enable, active low |
| ram_dq_o | output | 9 | Data toward the RAM |
| ram_dq_oe_o | output | 1 | Enable of the data driver toward the RAM |
| ram_dq_i | input | 9 | Data from the RAM |

## Verification
A wrong state or phase counter shows at once as a strobe run or an output-enable run of the wrong length. It also shows as a busy interval that differs from the computed cycle count, seen at req_ready_o in the same operation. A drive-enable error shows within one cycle as a bus overlap or as late write data. Read-back corrupts on the next read of that address. A wrong address latch shows as an address change during a strobe or during busy in the cycle it happens. Sweeps over spread addresses with arithmetic data patterns, run in both write modes, catch each of these within one operation.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_RECOV
  } seq_state_e;

  // ceil(ns / clk_ns), never below one cycle
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int CW           = 3,
  parameter int PULSE_C      = 3,
  parameter int WAIT_C       = 0,
  parameter int WREC_C       = 1,
  parameter int ACC_C        = 2,
  parameter int RREC_C       = 2,
  parameter bit OE_LOW_WRITE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  output logic ready_o,
  output logic accept_o,
  output logic sample_o,
  output logic we_n_o,
  output logic oe_n_o,
  output logic dq_oe_o
);

  localparam logic [CW-1:0] PULSE_L = CW'(PULSE_C - 1);
  localparam logic [CW-1:0] WREC_L  = CW'(WREC_C - 1);
  localparam logic [CW-1:0] ACC_L   = CW'(ACC_C - 1);
  localparam logic [CW-1:0] RREC_L  = CW'(RREC_C - 1);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d;
  logic          we_n_q, oe_n_q, dq_oe_q;
  logic          wr_oe_lo, drive_ok;

  assign ready_o  = (st_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;
  assign sample_o = (st_q == ST_READ) && (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    wr_d  = wr_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        st_d  = ST_ADDR;
        wr_d  = req_we_i;
        cnt_d = '0;
      end
      ST_ADDR: begin
        // address settled for one cycle with strobe high
        if (wr_q) begin
          st_d  = ST_WRITE;
          cnt_d = PULSE_L;
        end else begin
          st_d  = ST_READ;
          cnt_d = ACC_L;
        end
      end
      ST_WRITE: begin
        if (cnt_q == '0) begin
          st_d  = ST_RECOV;
          cnt_d = WREC_L;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_READ: begin
        if (cnt_q == '0) begin
          st_d  = ST_RECOV;
          cnt_d = RREC_L;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt_q == '0) st_d = ST_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  generate
    if (OE_LOW_WRITE) begin : g_oe_stretch
      assign wr_oe_lo = wr_d && ((st_d == ST_ADDR) || (st_d == ST_WRITE));
    end else begin : g_oe_plain
      assign wr_oe_lo = 1'b0;
    end
  endgenerate

  // wait out RAM turn-off before driving
  assign drive_ok = (int'(cnt_d) + WAIT_C) < PULSE_C;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      we_n_q  <= (st_d != ST_WRITE);
      oe_n_q  <= !((st_d == ST_READ) || wr_oe_lo);
      dq_oe_q <= ((st_d == ST_WRITE) && drive_ok) || ((st_d == ST_RECOV) && wr_d);
    end
  end

  assign we_n_o  = we_n_q;
  assign oe_n_o  = oe_n_q;
  assign dq_oe_o = dq_oe_q;

  p_no_fight_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !(we_n_o && !oe_n_o));

  p_oe_high_in_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!OE_LOW_WRITE && !we_n_o) |-> oe_n_o);

  p_busy_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !ready_o);

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (we_n_o && oe_n_o && !dq_oe_o && ready_o));

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          sample_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] ram_dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_done_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= sample_i;
      if (sample_i) rdata_q <= ram_dq_i;
    end
  end

  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign rd_data_o = rdata_q;
  assign rd_done_o = done_q;

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o);

endmodule

// File: rtl/sram_port_seq.sv
module sram_port_seq
  import sram_seq_pkg::*;
#(
  parameter int AW           = 12,
  parameter int DW           = 9,
  parameter int CLK_NS       = 4,
  parameter int T_WC         = 12,
  parameter int T_AW         = 10,
  parameter int T_WP         = 10,
  parameter int T_WR         = 1,
  parameter int T_DW         = 8,
  parameter int T_WZ         = 7,
  parameter int T_AA         = 12,
  parameter int T_AOE        = 8,
  parameter int T_HZ         = 7,
  parameter bit OE_LOW_WRITE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_done_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_we_n_o,
  output logic          ram_oe_n_o,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe_o,
  input  logic [DW-1:0] ram_dq_i
);

  localparam int WAIT_C  = OE_LOW_WRITE ? ns2cyc(T_WZ, CLK_NS) : 0;
  localparam int PULSE_C = imax(imax(ns2cyc(T_WP, CLK_NS), WAIT_C + ns2cyc(T_DW, CLK_NS)),
                                ns2cyc(T_AW, CLK_NS) - 1);
  localparam int WREC_C  = imax(ns2cyc(T_WR, CLK_NS), ns2cyc(T_WC, CLK_NS) - 1 - PULSE_C);
  localparam int ACC_C   = imax(imax(ns2cyc(T_AA, CLK_NS) - 1, ns2cyc(T_AOE, CLK_NS)), 1);
  localparam int RREC_C  = ns2cyc(T_HZ, CLK_NS);
  localparam int CNT_MAX = imax(imax(PULSE_C, WREC_C), imax(ACC_C, RREC_C));
  localparam int CW      = imax($clog2(CNT_MAX + 1), 1);

  logic accept, sample;

  sram_seq_ctrl #(
    .CW          (CW),
    .PULSE_C     (PULSE_C),
    .WAIT_C      (WAIT_C),
    .WREC_C      (WREC_C),
    .ACC_C       (ACC_C),
    .RREC_C      (RREC_C),
    .OE_LOW_WRITE(OE_LOW_WRITE)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .sample_o   (sample),
    .we_n_o     (ram_we_n_o),
    .oe_n_o     (ram_oe_n_o),
    .dq_oe_o    (ram_dq_oe_o)
  );

  sram_seq_dpath #(
    .AW(AW),
    .DW(DW)
  ) u_dpath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .sample_i   (sample),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .ram_dq_i   (ram_dq_i),
    .addr_o     (ram_addr_o),
    .wdata_o    (ram_dq_o),
    .rd_data_o  (rd_data_o),
    .rd_done_o  (rd_done_o)
  );

  // strobe-low run length, for the pulse-width checks
  logic [7:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_run_q <= '0;
    else if (ram_we_n_o) low_run_q <= '0;
    else if (low_run_q != 8'hff) low_run_q <= low_run_q + 8'd1;
  end

  p_addr_strobe_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ram_addr_o) |-> (ram_we_n_o && $past(ram_we_n_o)));

  p_addr_only_on_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ram_addr_o) |-> $past(req_valid_i && req_ready_o));

  p_pulse_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_n_o) |-> (int'(low_run_q) == PULSE_C));

  p_data_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_n_o) |-> ram_dq_oe_o);

  p_done_after_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> $past(!ram_oe_n_o));

endmodule

// File: tb/sim_sram_port_seq.sv
module sim_ram_model #(
  parameter int OFF_MIN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] addr,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [8:0]  din,
  input  logic        din_oe,
  output logic [8:0]  dout,
  output int          last_pulse,
  output int          last_wait,
  output int          viol_addr,
  output int          viol_bus,
  output int          oe_low_wr
);
  logic [8:0]  mem [4096];
  logic [11:0] a_prev;
  logic        we_prev, oe_prev_drv;
  int          run, off;

  assign dout = (we_n && !oe_n) ? mem[addr] : 9'h0aa;

  always @(posedge clk) begin
    if (!rst_n) begin
      a_prev <= addr; we_prev <= 1'b1; oe_prev_drv <= 1'b0;
      run <= 0; off <= 100; last_pulse <= 0; last_wait <= -1;
      viol_addr <= 0; viol_bus <= 0; oe_low_wr <= 0;
    end else begin
      if (addr != a_prev && (!we_n || !we_prev)) viol_addr <= viol_addr + 1;
      a_prev  <= addr;
      we_prev <= we_n;
      oe_prev_drv <= din_oe;
      if (!we_n) begin
        run <= run + 1;
        if (din_oe && !oe_prev_drv) last_wait <= run;
        if (din_oe) mem[addr] <= din;
        if (!oe_n) oe_low_wr <= oe_low_wr + 1;
      end else if (!we_prev) begin
        last_pulse <= run;
        run <= 0;
      end
      if (din_oe && ((we_n && !oe_n) || off < OFF_MIN)) viol_bus <= viol_bus + 1;
      off <= (we_n && !oe_n) ? 0 : ((off < 100) ? off + 1 : off);
    end
  end
endmodule

module sim_lane #(
  parameter bit STRETCH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_err,
  output bit   fin
);
  function automatic int cdiv(input int ns); return (ns + 3) / 4; endfunction
  function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction

  localparam int EXP_WAIT  = STRETCH ? cdiv(7) : 0;
  localparam int EXP_PULSE = mx(cdiv(10), EXP_WAIT + cdiv(8));
  localparam int EXP_WBUSY = 1 + EXP_PULSE + mx(1, cdiv(12) - 1 - EXP_PULSE);
  localparam int EXP_ACC   = mx(cdiv(12) - 1, cdiv(8));
  localparam int EXP_RBUSY = 1 + EXP_ACC + cdiv(7);
  localparam int EXP_DONE  = 2 + EXP_ACC;

  logic        req_valid, req_we, ready, done, we_n, oe_n, dq_oe;
  logic [11:0] req_addr, ram_addr;
  logic [8:0]  req_wdata, rd_data, dq_o, dq_i;
  int          last_pulse, last_wait, viol_addr, viol_bus, oe_low_wr;

  sram_port_seq #(.OE_LOW_WRITE(STRETCH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(ready),
    .rd_data_o(rd_data), .rd_done_o(done), .ram_addr_o(ram_addr),
    .ram_we_n_o(we_n), .ram_oe_n_o(oe_n), .ram_dq_o(dq_o),
    .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_i)
  );

  sim_ram_model #(.OFF_MIN(cdiv(7))) u_ram (
    .clk(clk), .rst_n(rst_n), .addr(ram_addr), .we_n(we_n), .oe_n(oe_n),
    .din(dq_o), .din_oe(dq_oe), .dout(dq_i), .last_pulse(last_pulse),
    .last_wait(last_wait), .viol_addr(viol_addr), .viol_bus(viol_bus),
    .oe_low_wr(oe_low_wr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s lane%0d: act=%0d exp=%0d", tag, STRETCH, act, exp);
    end
  endtask

  task automatic op(input bit we, input logic [11:0] a, input logic [8:0] d,
                    output int busy, output int done_at, output int ndone,
                    output logic [8:0] rd, output bit addr_ok);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    // keep a conflicting request up while busy
    req_we = !we; req_addr = ~a; req_wdata = ~d;
    busy = 0; done_at = 0; ndone = 0; rd = '0; addr_ok = 1'b1;
    while (!ready && busy < 64) begin
      busy++;
      if (done) begin done_at = busy; ndone++; rd = rd_data; end
      if (ram_addr != a) addr_ok = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  function automatic logic [11:0] addr_of(input int i); return 12'(i * 16 + (i % 16)); endfunction
  function automatic logic [8:0] data_of(input int i); return 9'((i * 37 + 5) % 512); endfunction

  initial begin
    int busy, done_at, ndone;
    logic [8:0] rd;
    bit aok;
    n_chk = 0; n_err = 0; fin = 1'b0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    @(negedge clk);
    // R1 reset state
    chk(we_n && oe_n && !dq_oe && !done && ready, "R1", {we_n, oe_n, dq_oe, done, ready}, 5'b11001);
    wait (rst_n);
    @(negedge clk);
    chk(we_n && oe_n && !dq_oe && ready, "R1", {we_n, oe_n, dq_oe, ready}, 4'b1101);

    for (int i = 0; i < 256; i++) begin
      op(1'b1, addr_of(i), data_of(i), busy, done_at, ndone, rd, aok);
      chk(busy == EXP_WBUSY, "R9", busy, EXP_WBUSY);
      chk(ndone == 0, "R8", ndone, 0);
      chk(aok, "R10", aok, 1);
      chk(last_pulse == EXP_PULSE, STRETCH ? "R5" : "R3", last_pulse, EXP_PULSE);
      chk(last_wait == EXP_WAIT, STRETCH ? "R5" : "R6", last_wait, EXP_WAIT);
    end
    // data extremes and overwrite
    op(1'b1, 12'd1, 9'h1ff, busy, done_at, ndone, rd, aok);
    op(1'b1, 12'd2, 9'h000, busy, done_at, ndone, rd, aok);
    op(1'b1, 12'd2, 9'h155, busy, done_at, ndone, rd, aok);
    op(1'b1, 12'd2, 9'h0cb, busy, done_at, ndone, rd, aok);

    for (int i = 0; i < 256; i++) begin
      op(1'b0, addr_of(i), 9'h000, busy, done_at, ndone, rd, aok);
      chk(busy == EXP_RBUSY, "R9", busy, EXP_RBUSY);
      chk(ndone == 1, "R8", ndone, 1);
      chk(done_at == EXP_DONE, "R8", done_at, EXP_DONE);
      chk(rd == data_of(i), "R7", rd, data_of(i));
      chk(aok, "R10", aok, 1);
    end
    op(1'b0, 12'd1, 9'h000, busy, done_at, ndone, rd, aok);
    chk(rd == 9'h1ff, "R7", rd, 9'h1ff);
    op(1'b0, 12'd2, 9'h000, busy, done_at, ndone, rd, aok);
    chk(rd == 9'h0cb, "R7", rd, 9'h0cb);

    chk(viol_addr == 0, "R2", viol_addr, 0);
    chk(viol_bus == 0, "R6", viol_bus, 0);
    if (STRETCH) chk(oe_low_wr > 0, "R5", oe_low_wr, 1);
    else chk(oe_low_wr == 0, "R4", oe_low_wr, 0);
    fin = 1'b1;
  end
endmodule

module sim_sram_port_seq;
  logic clk = 1'b0;
  logic rst_n;
  int   c0, e0, c1, e1;
  bit   f0, f1;
  int   cycles = 0;
  bit   timeout = 1'b0;

  always #2 clk = ~clk;

  sim_lane #(.STRETCH(1'b0)) u_plain   (.clk(clk), .rst_n(rst_n), .n_chk(c0), .n_err(e0), .fin(f0));
  sim_lane #(.STRETCH(1'b1)) u_stretch (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_err(e1), .fin(f1));

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    #20 rst_n = 1'b1;
  end

  initial begin
    while (!(f0 && f1) && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!(f0 && f1)) begin
      timeout = 1'b1;
      $display("FAIL watchdog: act=%0d exp=done", cycles);
    end
    #1;
    $display("Simulation finished: %0d checks, %0d errors",
             c0 + c1 + (timeout ? 1 : 0), e0 + e1 + (timeout ? 1 : 0));
    $finish;
  end
endmodule